// File: doc/BRIEF.md
# Multi-Channel Supply Reset Generator

This block turns four synchronous supply-comparator flags into one active-low system reset. A fault on any channel pulls the reset low combinationally, in the same cycle. The reset is released only after every channel has been good for one full timeout window. The window is counted in clock cycles. It is either a fixed default set by a parameter (about 200 ms at the target clock) or a value presented on a port.

Each channel has a 4-bit configuration code. The code is captured on the first clock after power-on reset and is frozen from then on. The code picks one of fourteen undervoltage thresholds, a positive-adjust mode or a negative-adjust mode. Only negative-adjust changes what the block does: it inverts that channel's fault sense.

A debounced active-low manual reset input forces the output low. A reset-disable input holds the output high so that supply margining does not reset the system.

Top module: `rst_supervisor`

## Requirements
- R1: While `rdis` is low and any channel reports a fault, `sys_rst_n` is low in that same cycle, with no register in the path.
- R2: `sys_rst_n` rises only after a window in which every channel is good, the accepted manual-reset level is high and the configuration is captured, for a run of consecutive rising edges equal to the timeout length.
- R3: With `tmo_sel` = 0 the timeout is `DEFAULT_TMO_CYCLES` edges. With `tmo_sel` = 1 it is `tmo_prog` edges, and a value of 0 counts as 1.
- R4: The code 15 (negative-adjust) makes a channel faulty when its `ch_above` bit is 1. Codes 0 to 13 (undervoltage thresholds) and 14 (positive-adjust) make it faulty when the bit is 0. Channel i's code sits in `cfg_code[4*i+3:4*i]`.
- R5: The codes are taken on the first rising edge after `por_n` goes high. Later changes on `cfg_code` have no effect.
- R6: An accepted low level on manual reset drives `sys_rst_n` low. After the accepted level returns high, the release follows R2.
- R7: The manual-reset input is accepted at a new level only after it has differed from the accepted level on `DEB_CYCLES` consecutive edges. A shorter pulse is ignored.
- R8: While `rdis` is high, `sys_rst_n` is high, even during faults or manual reset.
- R9: From power-on reset, `sys_rst_n` stays low through the capture edge and the first complete timeout. With good supplies it rises on edge 1 + timeout after `por_n` goes high.
- R10: A fault or an accepted manual reset during the timeout count restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset |
| cfg_code | input | 16 | Four 4-bit channel codes, channel 0 in the low nibble |
| ch_above | input | 4 | Per-channel comparator flag, 1 = level above its threshold |
| mr_n | input | 1 | Active-low manual reset, raw |
| rdis | input | 1 | Reset disable, forces output high |
| tmo_sel | input | 1 | 0 = default timeout, 1 = programmed timeout |
| tmo_prog | input | CNT_W | Programmed timeout in cycles |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
On every cycle, the bound checker confirms the following:
- any fault, or an accepted manual reset, holds the output low unless disable is set;
- disable always wins;
- the output stays low before capture;
- the captured polarity never changes after capture;
- a release is only ever preceded by a good cycle.

Only the directed scenarios can show the exact edge at which the output rises for each timeout choice. They also show that a short manual-reset glitch is ignored, that a mid-count fault restarts the full window, and that a negative-adjust channel faults on a high flag.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
   localparam int CODE_W = 4;
   localparam logic [CODE_W-1:0] CODE_POS_ADJ = 4'd14;
   localparam logic [CODE_W-1:0] CODE_NEG_ADJ = 4'd15;

   typedef enum logic [1:0] {
      SENSE_UNDER   = 2'd0,
      SENSE_POS_ADJ = 2'd1,
      SENSE_NEG_ADJ = 2'd2
   } sense_e;

   function automatic sense_e decode_sense(logic [CODE_W-1:0] code);
      sense_e s;
      if (code == CODE_NEG_ADJ)      s = SENSE_NEG_ADJ;
      else if (code == CODE_POS_ADJ) s = SENSE_POS_ADJ;
      else                           s = SENSE_UNDER;
      return s;
   endfunction
endpackage

// File: rtl/rstgen_cfg_latch.sv
module rstgen_cfg_latch
   import rstgen_pkg::*;
#(
   parameter int N_CH = 4
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic [N_CH*CODE_W-1:0]   cfg_code,
   output logic                     cfg_valid,
   output logic [N_CH-1:0]          inv_vec
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) cfg_valid <= 1'b0;
      else        cfg_valid <= 1'b1;
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      sense_e sense_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            sense_q <= SENSE_UNDER;
         else if (!cfg_valid)
            sense_q <= decode_sense(cfg_code[g*CODE_W +: CODE_W]);
      end
      assign inv_vec[g] = (sense_q == SENSE_NEG_ADJ);
   end
endmodule

// File: rtl/rstgen_fault_map.sv
module rstgen_fault_map #(
   parameter int N_CH = 4
) (
   input  logic [N_CH-1:0] ch_above,
   input  logic [N_CH-1:0] inv_vec,
   output logic [N_CH-1:0] fault_vec,
   output logic            any_fault
);
   for (genvar g = 0; g < N_CH; g++) begin : g_map
      assign fault_vec[g] = inv_vec[g] ? ch_above[g] : ~ch_above[g];
   end
   assign any_fault = |fault_vec;
endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
   parameter int STABLE_CYCLES = 16,
   localparam int CW = $clog2(STABLE_CYCLES + 1)
) (
   input  logic clk,
   input  logic por_n,
   input  logic raw_in,
   output logic level_q
);
   logic [CW-1:0] cnt_q;

   if (STABLE_CYCLES < 1) begin : g_bad
      $error("rstgen_debounce: STABLE_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         level_q <= 1'b1;
         cnt_q   <= '0;
      end else if (raw_in == level_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
         level_q <= raw_in;
         cnt_q   <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rstgen_delay.sv
module rstgen_delay #(
   parameter int CNT_W              = 25,
   parameter int DEFAULT_TMO_CYCLES = 20_000_000
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             run,
   input  logic             tmo_sel,
   input  logic [CNT_W-1:0] tmo_prog,
   output logic             released
);
   localparam logic [CNT_W-1:0] DEF_LIMIT = CNT_W'(DEFAULT_TMO_CYCLES);

   if (CNT_W < 2 || CNT_W > 40) begin : g_bad_w
      $error("rstgen_delay: CNT_W out of range");
   end
   if (DEFAULT_TMO_CYCLES < 1 ||
       longint'(DEFAULT_TMO_CYCLES) > ((longint'(1) << CNT_W) - 1)) begin : g_bad_d
      $error("rstgen_delay: DEFAULT_TMO_CYCLES does not fit CNT_W");
   end

   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (!tmo_sel)              limit = DEF_LIMIT;
      else if (tmo_prog == '0)   limit = CNT_W'(1);
      else                       limit = tmo_prog;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q    <= '0;
         released <= 1'b0;
      end else if (!run) begin
         cnt_q    <= '0;
         released <= 1'b0;
      end else if (!released) begin
         if (cnt_q >= limit - 1'b1) begin
            released <= 1'b1;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
   import rstgen_pkg::*;
#(
   parameter int N_CH               = 4,
   parameter int CNT_W              = 25,
   parameter int DEFAULT_TMO_CYCLES = 20_000_000,
   parameter int DEB_CYCLES         = 16
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic [N_CH*CODE_W-1:0] cfg_code,
   input  logic [N_CH-1:0]        ch_above,
   input  logic                   mr_n,
   input  logic                   rdis,
   input  logic                   tmo_sel,
   input  logic [CNT_W-1:0]       tmo_prog,
   output logic                   sys_rst_n
);
   if (N_CH < 1) begin : g_bad_n
      $error("rst_supervisor: N_CH must be positive");
   end

   logic            cfg_valid;
   logic [N_CH-1:0] inv_vec;
   logic [N_CH-1:0] fault_vec;
   logic            any_fault;
   logic            mr_db;
   logic            run;
   logic            released;

   rstgen_cfg_latch #(.N_CH(N_CH)) u_cfg (
      .clk(clk), .por_n(por_n), .cfg_code(cfg_code),
      .cfg_valid(cfg_valid), .inv_vec(inv_vec)
   );

   rstgen_fault_map #(.N_CH(N_CH)) u_map (
      .ch_above(ch_above), .inv_vec(inv_vec),
      .fault_vec(fault_vec), .any_fault(any_fault)
   );

   rstgen_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_deb (
      .clk(clk), .por_n(por_n), .raw_in(mr_n), .level_q(mr_db)
   );

   assign run = cfg_valid & ~any_fault & mr_db;

   rstgen_delay #(.CNT_W(CNT_W), .DEFAULT_TMO_CYCLES(DEFAULT_TMO_CYCLES)) u_dly (
      .clk(clk), .por_n(por_n), .run(run), .tmo_sel(tmo_sel),
      .tmo_prog(tmo_prog), .released(released)
   );

   assign sys_rst_n = rdis | (released & run);
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
   parameter int N_CH = 4
) (
   input logic            clk,
   input logic            por_n,
   input logic            rdis,
   input logic            sys_rst_n,
   input logic            cfg_valid,
   input logic [N_CH-1:0] inv_vec,
   input logic [N_CH-1:0] fault_vec,
   input logic            mr_db,
   input logic            released
);
   a_r1_fault_low: assert property (@(posedge clk) disable iff (!por_n)
      (!rdis && |fault_vec) |-> !sys_rst_n);

   a_r8_disable_high: assert property (@(posedge clk) disable iff (!por_n)
      rdis |-> sys_rst_n);

   a_r9_low_before_capture: assert property (@(posedge clk) disable iff (!por_n)
      (!cfg_valid && !rdis) |-> !sys_rst_n);

   a_r5_codes_frozen: assert property (@(posedge clk) disable iff (!por_n)
      cfg_valid |=> (cfg_valid && $stable(inv_vec)));

   a_r6_manual_low: assert property (@(posedge clk) disable iff (!por_n)
      (!mr_db && !rdis) |-> !sys_rst_n);

   a_r2_release_after_good: assert property (@(posedge clk) disable iff (!por_n)
      $rose(released) |-> $past(mr_db && !(|fault_vec) && cfg_valid));

   a_r10_fault_restarts: assert property (@(posedge clk) disable iff (!por_n)
      (|fault_vec || !mr_db) |=> !released);
endmodule

bind rst_supervisor rst_supervisor_chk #(.N_CH(N_CH)) u_chk (
   .clk(clk), .por_n(por_n), .rdis(rdis), .sys_rst_n(sys_rst_n),
   .cfg_valid(cfg_valid), .inv_vec(inv_vec), .fault_vec(fault_vec),
   .mr_db(mr_db), .released(released)
);

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
   localparam int N_CH  = 4;
   localparam int CNT_W = 16;
   localparam int DEF   = 20;
   localparam int DEB   = 16;

   logic             clk = 1'b0;
   logic             por_n;
   logic [15:0]      cfg_code;
   logic [3:0]       ch_above;
   logic             mr_n, rdis, tmo_sel;
   logic [CNT_W-1:0] tmo_prog;
   logic             sys_rst_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rst_supervisor #(.N_CH(N_CH), .CNT_W(CNT_W), .DEFAULT_TMO_CYCLES(DEF),
                    .DEB_CYCLES(DEB)) uut (
      .clk(clk), .por_n(por_n), .cfg_code(cfg_code), .ch_above(ch_above),
      .mr_n(mr_n), .rdis(rdis), .tmo_sel(tmo_sel), .tmo_prog(tmo_prog),
      .sys_rst_n(sys_rst_n)
   );

   // ch2 is negative-adjust: good when its flag is 0
   localparam logic [3:0] ALL_GOOD = 4'b1011;

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: sys_rst_n=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_edges(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // output must stay low for n-1 edges and be high after edge n
   task automatic expect_release(string req, int n);
      wait_edges(n - 1);
      chk(req, sys_rst_n, 1'b0);
      wait_edges(1);
      chk(req, sys_rst_n, 1'b1);
   endtask

   task automatic t_power_on;
      por_n = 1'b0; cfg_code = {4'd14, 4'd15, 4'd7, 4'd3};
      ch_above = ALL_GOOD; mr_n = 1'b1; rdis = 1'b0; tmo_sel = 1'b0; tmo_prog = '0;
      wait_edges(3);
      chk("R9 reset state", sys_rst_n, 1'b0);
      por_n = 1'b1;
      expect_release("R9 first release", 1 + DEF);
   endtask

   task automatic t_fault_immediate;
      ch_above[0] = 1'b0;
      #1 chk("R1 same-cycle fault", sys_rst_n, 1'b0);
      @(negedge clk);
      ch_above[0] = 1'b1;
      expect_release("R2 default window", DEF);
   endtask

   task automatic t_neg_adjust;
      ch_above[2] = 1'b1;
      #1 chk("R4 neg-adjust high faults", sys_rst_n, 1'b0);
      @(negedge clk);
      ch_above[2] = 1'b0;
      ch_above[3] = 1'b0;   // code 14, positive-adjust: low is a fault
      #1 chk("R4 pos-adjust low faults", sys_rst_n, 1'b0);
      @(negedge clk);
      ch_above = ALL_GOOD;
      expect_release("R4 recovery", DEF);
   endtask

   task automatic t_restart;
      ch_above[1] = 1'b0;
      @(negedge clk);
      ch_above[1] = 1'b1;
      wait_edges(10);
      ch_above[1] = 1'b0;
      @(negedge clk);
      ch_above[1] = 1'b1;
      expect_release("R10 restart count", DEF);
   endtask

   task automatic t_prog_timeout;
      tmo_sel = 1'b1; tmo_prog = 16'd7;
      ch_above[0] = 1'b0;
      @(negedge clk);
      ch_above[0] = 1'b1;
      expect_release("R3 programmed 7", 7);
      tmo_prog = 16'd0;
      ch_above[0] = 1'b0;
      @(negedge clk);
      ch_above[0] = 1'b1;
      #1 chk("R3 zero before edge", sys_rst_n, 1'b0);
      wait_edges(1);
      chk("R3 zero counts as 1", sys_rst_n, 1'b1);
      tmo_sel = 1'b0;
   endtask

   task automatic t_manual;
      mr_n = 1'b0;
      wait_edges(DEB - 1);
      chk("R7 not yet accepted", sys_rst_n, 1'b1);
      wait_edges(1);
      chk("R6 manual low", sys_rst_n, 1'b0);
      mr_n = 1'b1;
      expect_release("R6 manual release", DEB + DEF);
   endtask

   task automatic t_glitch;
      mr_n = 1'b0;
      wait_edges(DEB - 2);
      mr_n = 1'b1;
      wait_edges(DEB + 4);
      chk("R7 glitch ignored", sys_rst_n, 1'b1);
   endtask

   task automatic t_disable;
      rdis = 1'b1;
      ch_above[3] = 1'b0;
      #1 chk("R8 disable with fault", sys_rst_n, 1'b1);
      wait_edges(3);
      rdis = 1'b0;
      #1 chk("R1 fault visible after disable", sys_rst_n, 1'b0);
      ch_above[3] = 1'b1;
      @(negedge clk);
      expect_release("R2 release after disable", DEF - 1);
   endtask

   task automatic t_cfg_locked;
      cfg_code = {4'd15, 4'd15, 4'd15, 4'd15};
      wait_edges(5);
      chk("R5 codes frozen", sys_rst_n, 1'b1);
   endtask

   initial begin
      t_power_on();
      t_fault_immediate();
      t_neg_adjust();
      t_restart();
      t_prog_timeout();
      t_manual();
      t_glitch();
      t_disable();
      t_cfg_locked();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: sys_rst_n=%b expected completion", sys_rst_n);
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule